// File: doc/BRIEF.md
# Chip-Select Serial Status Readout Port

This block is a read-only three-wire serial port for a position-sensing front end. The host pulls an active-low select line low. The port then takes one snapshot of a loss-of-signal flag, an underrange flag, an overrange flag and an offset-binary displacement value. It then presents that word one bit at a time on a serial data line, and each rising edge of a host-supplied serial clock advances the line to the next bit. The host samples each bit before it sends the next rising edge, for example on the falling edge.

The select and serial clock inputs are asynchronous to the block. Each one passes through a synchroniser, and its edges are detected in the system clock domain. While select is high, the data line is released to high impedance, so several ports can share one data wire. A separate output-enable output drives the pad. The flag and position inputs are plain level inputs that are sampled at capture. They have no handshake, and the port never applies back-pressure to the front end. The host sets the pace of a frame only through the serial clock.

The size of the frame follows from the parameters. With the default 13-bit position, a frame is 16 bits.

Top module: `ssr_status_port`

## Requirements
- R1: After reset the data output is disabled (`sdo_oe_o` = 0) and stays disabled until select is driven low.
- R2: A frame is sent MSB first in this bit order, where bit k is the value presented after k rising serial clock edges:
  - bit 0 is the loss-of-signal flag;
  - bit 1 is the underrange flag;
  - bit 2 is the overrange flag;
  - bits 3 to 15 are the position input, most significant bit first and unchanged.
- R3: The frame holds the values the inputs had at the moment of capture. Changes to the flag or position inputs after capture have no effect on the bits sent during that frame.
- R4: Only rising serial clock edges advance the output. Falling edges, and intervals with no edge, leave the presented bit unchanged.
- R5: Every serial clock rising edge after the last frame bit presents the value 1.
- R6: When select is high, `sdo_oe_o` goes to 0 within 3 system clock cycles and `sdo_o` is high impedance. Serial clock edges while select is high do not enable the output.
- R7: Raising select before the frame ends aborts the frame. The next select low starts a new frame at bit 0 from a fresh snapshot.
- R8: Capture takes effect on the third system clock edge after select falls. The port works correctly when each serial clock phase lasts at least 2 system clock periods and the first rising edge comes at least 2 system clock periods after select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| los_i | input | 1 | Loss-of-signal flag to capture |
| unr_i | input | 1 | Underrange flag to capture |
| ovr_i | input | 1 | Overrange flag to capture |
| pos_i | input | POS_W | Offset-binary displacement to capture |
| sdo_o | output | 1 | Serial data, high impedance when disabled |
| sdo_oe_o | output | 1 | Output enable for the data pad |

## Verification
Several directed frames are read in full:
- a frame of all-zero inputs, which exposes a missing fill of ones past the end of the frame;
- a frame with only one flag set, which tells the flag positions apart from each other;
- a frame with a walking position value, which catches a bit-order or bit-shift error.

Randomised frames use random flag and position words, random serial clock phase lengths down to the minimum, and random overrun lengths. After every capture the inputs are scrambled, so a port that samples live data instead of its snapshot shows up. Some frames are aborted part way, and serial clock toggling while select is high checks that the bus is released and that the next frame restarts at bit 0.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int FLAG_W = 3;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } port_state_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= RST_VAL;
      end else if (s == 0) begin
        chain_q[s] <= async_i;
      end else begin
        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= word_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], 1'b1};
    end
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/ssr_port_ctl.sv
module ssr_port_ctl
  import ssr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_level_i,
  input  logic sel_fall_i,
  input  logic clk_rise_i,
  output logic load_o,
  output logic shift_o,
  output logic drive_o
);
  port_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_fall_i) begin
          load_o  = 1'b1;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sel_level_i) begin
          state_d = ST_IDLE;
        end else begin
          shift_o = clk_rise_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign drive_o = (state_q == ST_SHIFT);
endmodule

// File: rtl/ssr_status_port.sv
module ssr_status_port
  import ssr_pkg::*;
#(
  parameter int POS_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             los_i,
  input  logic             unr_i,
  input  logic             ovr_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int FRAME_W = POS_W + FLAG_W;

  logic               cs_level, cs_fall, cs_rise_unused;
  logic               sclk_level_unused, sclk_rise, sclk_fall_unused;
  logic               load, shift, drive, sdo_bit;
  logic [FRAME_W-1:0] frame_word;

  ssr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n_i),
    .level_o(cs_level), .rise_o(cs_rise_unused), .fall_o(cs_fall)
  );

  ssr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
    .level_o(sclk_level_unused), .rise_o(sclk_rise), .fall_o(sclk_fall_unused)
  );

  ssr_port_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .sel_level_i(cs_level), .sel_fall_i(cs_fall), .clk_rise_i(sclk_rise),
    .load_o(load), .shift_o(shift), .drive_o(drive)
  );

  assign frame_word = {los_i, unr_i, ovr_i, pos_i};

  ssr_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .word_i(frame_word), .shift_i(shift),
    .msb_o(sdo_bit)
  );

  assign sdo_oe_o = drive;
  assign sdo_o    = drive ? sdo_bit : 1'bz;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_level,
  input logic cs_fall,
  input logic sclk_rise,
  input logic los_i,
  input logic sdo_bit,
  input logic sdo_oe
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] shifts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifts_q <= '0;
    end else if (cs_fall) begin
      shifts_q <= '0;
    end else if (sdo_oe && !cs_level && sclk_rise && shifts_q != CW'(W)) begin
      shifts_q <= shifts_q + 1'b1;
    end
  end

  // R2, R8: the loss flag is presented one cycle after the select fall is seen
  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && sdo_bit == $past(los_i)));

  // R6: select high releases the bus on the next cycle
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_level |=> !sdo_oe);

  // R4: without a rising serial clock edge or a capture, the bit holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !cs_fall) |=> $stable(sdo_bit));

  // R5: once all frame bits are shifted out, the line reads 1
  p_fill_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && shifts_q == CW'(W)) |-> sdo_bit);
endmodule

bind ssr_status_port ssr_chk #(.W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_level(cs_level), .cs_fall(cs_fall),
  .sclk_rise(sclk_rise), .los_i(los_i), .sdo_bit(sdo_bit), .sdo_oe(sdo_oe_o)
);

// File: tb/sim_ssr_status_port.sv
`timescale 1ns/1ps
module sim_ssr_status_port;
  localparam int POS_W = 13;
  localparam int FW    = POS_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0;
  logic los = 1'b0, unr = 1'b0, ovr = 1'b0;
  logic [POS_W-1:0] pos = '0;
  wire  sdo;
  wire  sdo_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssr_status_port #(.POS_W(POS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .los_i(los), .unr_i(unr), .ovr_i(ovr), .pos_i(pos),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  function automatic logic exp_bit(logic [FW-1:0] w, int k);
    return (k < FW) ? w[FW-1-k] : 1'b1;
  endfunction

  function automatic string req_of(int k);
    if (k >= FW) return "R5";
    return "R2/R3";
  endfunction

  task automatic chk(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: nrise rising edges, abort after abort_at edges (-1 = none)
  task automatic frame(logic l, logic u, logic o, logic [POS_W-1:0] p,
                       int nrise, int hi, int lo, int abort_at);
    logic [FW-1:0] w;
    w = {l, u, o, p};
    los = l; unr = u; ovr = o; pos = p;
    cs_n = 1'b0;
    wait_clk(3);                         // R8: capture on the third edge
    los = ~l; unr = ~u; ovr = ~o; pos = $urandom;  // R3: scramble after capture
    chk("R8 oe", int'(sdo_oe), 1);
    chk("R2 bit0", int'(sdo), int'(exp_bit(w, 0)));
    for (int k = 1; k <= nrise; k++) begin
      sclk = 1'b1; wait_clk(hi);
      sclk = 1'b0; wait_clk(lo);
      chk("oe", int'(sdo_oe), 1);
      chk(req_of(k), int'(sdo), int'(exp_bit(w, k)));   // R4 advance per rise
      if (k == abort_at) break;
    end
    cs_n = 1'b1;
    wait_clk(4);
    chk("R6 release", int'(sdo_oe), 0);
    for (int t = 0; t < 2; t++) begin      // R6: clock while deselected
      sclk = 1'b1; wait_clk(3); sclk = 1'b0; wait_clk(3);
      chk("R6 ignored sclk", int'(sdo_oe), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_clk(4);
    chk("R1 reset oe", int'(sdo_oe), 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 idle oe", int'(sdo_oe), 0);

    // R5: zeros then overrun of ones
    frame(1'b0, 1'b0, 1'b0, '0, FW + 3, 3, 3, -1);
    // R2: single flags tell positions apart
    frame(1'b1, 1'b0, 1'b0, '0, FW, 3, 3, -1);
    frame(1'b0, 1'b1, 1'b0, 13'h1fff, FW, 3, 3, -1);
    frame(1'b0, 1'b0, 1'b1, 13'h1000, FW, 3, 3, -1);
    // R2: walking position bit
    for (int b = 0; b < POS_W; b += 4)
      frame(1'b0, 1'b0, 1'b0, POS_W'(1) << b, FW, 3, 3, -1);
    // R4: long high phase, falling edge must not advance
    los = 1'b1; unr = 1'b0; ovr = 1'b1; pos = 13'h0a5a;
    cs_n = 1'b0; wait_clk(3);
    sclk = 1'b1; wait_clk(6);
    chk("R4 after rise", int'(sdo), 0);
    sclk = 1'b0; wait_clk(6);
    chk("R4 fall no advance", int'(sdo), 0);
    cs_n = 1'b1; wait_clk(4);
    // R7: abort part way, then full fresh frame
    frame(1'b1, 1'b1, 1'b0, 13'h0f0f, FW, 3, 3, 5);
    frame(1'b0, 1'b1, 1'b1, 13'h1234, FW, 3, 3, -1);   // R7 restart at bit 0
    // R8: minimum phase lengths
    frame(1'b1, 1'b0, 1'b1, 13'h15a3, FW + 1, 2, 2, -1);

    for (int i = 0; i < 40; i++) begin
      int ab;
      ab = ($urandom % 4 == 0) ? int'($urandom % FW) + 1 : -1;
      frame(1'($urandom), 1'($urandom), 1'($urandom), POS_W'($urandom),
            FW + int'($urandom % 4), 2 + int'($urandom % 4),
            2 + int'($urandom % 4), ab);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule